// File: doc/BRIEF.md
# Prescaled Sigma-Delta Modulator Bank

The bank holds four independent first-order sigma-delta modulators, each turning an 8-bit density code into a single-bit pulse stream. Over any run of 256 modulator steps, the number of high output bits equals the density code. Each channel has its own 8-bit prescale value. This value divides the module clock, so a channel takes one modulator step every prescale+1 clocks. A single bank-wide enable gates all channels at once. While that enable is low, every divider, accumulator and output holds its value.

Configuration arrives through a one-cycle write port: one strobe, a word address and a data word. Each output bit can feed a pad driver or an external RC filter to form a low-cost DAC.

Top module: `sdm_bank`

## Requirements
- R1: After reset every output is 0, the bank enable is 0, every density is 0 and every prescale is 255 (all ones).
- R2: While the bank enable is 0, no output, divider or accumulator changes, though configuration writes still land.
- R3: With prescale N and the bank enabled, a channel steps exactly once every N+1 clocks. The first step comes N+1 clocks after the divider starts from zero.
- R4: On a step, the 8-bit residue plus the density forms a 9-bit sum. The low 8 bits become the new residue and bit 8 drives the output, registered.
- R5: Over any 256 consecutive steps at constant density D, a channel outputs exactly D ones.
- R6: A write to a channel's prescale register clears that channel's divider, and no step happens in the cycle of the write.
- R7: Density 0 gives a constant 0 and density 255 gives 255 ones in every 256 steps.
- R8: The address map is as follows. Address 0 bit 0 is the bank enable. Address 2k+1 holds the density of channel k. Address 2k+2 holds the prescale of channel k. A write changes only the register it addresses.
- R9: Writes to addresses above 2·NUM_CH change no register.
- R10: A write to the enable register takes effect from the following clock. The step in the write cycle uses the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe, one write per cycle |
| cfg_addr | input | 4 | Word address of the write |
| cfg_wdata | input | 8 | Write data |
| pdm_out | output | 4 | One pulse-density bit per channel |

## Verification
The assertions assume that cfg_we, cfg_addr and cfg_wdata are settled at every rising edge. They also assume that at most one register changes per cycle, which is the only kind of write the port can express. The bench therefore drives every input on the falling edge and never stacks two writes into one cycle. Random prescale values stay small so that many steps fall within the run. Random addresses span the full 4-bit range, so the unmapped decode gets exercised.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   // address of the bank-wide enable register
   localparam int unsigned GATE_ADDR = 0;

   // per-channel register addresses
   function automatic int unsigned dens_addr(input int unsigned ch);
      return 2 * ch + 1;
   endfunction

   function automatic int unsigned pre_addr(input int unsigned ch);
      return 2 * ch + 2;
   endfunction

   // highest mapped address for a given channel count
   function automatic int unsigned last_addr(input int unsigned nch);
      return 2 * nch;
   endfunction

endpackage

// File: rtl/sdm_cfg_regs.sv
module sdm_cfg_regs #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DENS_W = 8,
   parameter int unsigned PRE_W  = 8,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic                     bank_en,
   output logic [NUM_CH*DENS_W-1:0] dens_flat,
   output logic [NUM_CH*PRE_W-1:0]  pre_flat,
   output logic [NUM_CH-1:0]        pre_wr
);
   import sdm_pkg::*;

   logic gate_hit;
   assign gate_hit = we && (addr == ADDR_W'(GATE_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bank_en <= 1'b0;
      else if (gate_hit) bank_en <= wdata[0];
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic dens_hit;
      logic [DENS_W-1:0] dens_q;
      logic [PRE_W-1:0]  pre_q;

      assign dens_hit   = we && (addr == ADDR_W'(dens_addr(ch)));
      assign pre_wr[ch] = we && (addr == ADDR_W'(pre_addr(ch)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        dens_q <= '0;
         else if (dens_hit) dens_q <= wdata[DENS_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pre_q <= '1;
         else if (pre_wr[ch]) pre_q <= wdata[PRE_W-1:0];
      end

      assign dens_flat[ch*DENS_W +: DENS_W] = dens_q;
      assign pre_flat[ch*PRE_W +: PRE_W]    = pre_q;
   end

endmodule

// File: rtl/sdm_divider.sv
module sdm_divider #(
   parameter int unsigned PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] pre,
   output logic             tick
);
   logic [PRE_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == pre);
   assign tick   = run && !restart && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (run)     cnt_q <= at_end ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/sdm_accum.sv
module sdm_accum #(
   parameter int unsigned DENS_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [DENS_W-1:0] dens,
   output logic              bit_out
);
   logic [DENS_W-1:0] resid_q;
   logic [DENS_W:0]   sum;

   assign sum = {1'b0, resid_q} + {1'b0, dens};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resid_q <= '0;
         bit_out <= 1'b0;
      end else if (step) begin
         resid_q <= sum[DENS_W-1:0];
         bit_out <= sum[DENS_W];
      end
   end

endmodule

// File: rtl/sdm_channel.sv
module sdm_channel #(
   parameter int unsigned DENS_W = 8,
   parameter int unsigned PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [PRE_W-1:0]  pre,
   input  logic [DENS_W-1:0] dens,
   output logic              tick,
   output logic              bit_out
);
   sdm_divider #(.PRE_W(PRE_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (restart),
      .pre     (pre),
      .tick    (tick)
   );

   sdm_accum #(.DENS_W(DENS_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (tick),
      .dens    (dens),
      .bit_out (bit_out)
   );

endmodule

// File: rtl/sdm_bank.sv
module sdm_bank #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DENS_W = 8,
   parameter int unsigned PRE_W  = 8,
   localparam int unsigned DATA_W = (DENS_W > PRE_W) ? DENS_W : PRE_W,
   localparam int unsigned ADDR_W = $clog2(2 * NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [NUM_CH-1:0] pdm_out
);
   if (NUM_CH < 1) begin : g_bad_nch
      $error("sdm_bank: NUM_CH must be at least 1");
   end
   if (DENS_W < 2 || DENS_W > 16) begin : g_bad_dens
      $error("sdm_bank: DENS_W must be within 2..16");
   end
   if (PRE_W < 1 || PRE_W > 16) begin : g_bad_pre
      $error("sdm_bank: PRE_W must be within 1..16");
   end

   logic                     bank_en;
   logic [NUM_CH*DENS_W-1:0] dens_flat;
   logic [NUM_CH*PRE_W-1:0]  pre_flat;
   logic [NUM_CH-1:0]        pre_wr;
   logic [NUM_CH-1:0]        step_tick;

   sdm_cfg_regs #(
      .NUM_CH (NUM_CH),
      .DENS_W (DENS_W),
      .PRE_W  (PRE_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .bank_en   (bank_en),
      .dens_flat (dens_flat),
      .pre_flat  (pre_flat),
      .pre_wr    (pre_wr)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      sdm_channel #(
         .DENS_W (DENS_W),
         .PRE_W  (PRE_W)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (bank_en),
         .restart (pre_wr[ch]),
         .pre     (pre_flat[ch*PRE_W +: PRE_W]),
         .dens    (dens_flat[ch*DENS_W +: DENS_W]),
         .tick    (step_tick[ch]),
         .bit_out (pdm_out[ch])
      );
   end

endmodule

// File: rtl/sdm_bank_chk.sv
module sdm_bank_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DENS_W = 8,
   parameter int unsigned PRE_W  = 8,
   parameter int unsigned ADDR_W = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_we,
   input logic [ADDR_W-1:0]        cfg_addr,
   input logic [NUM_CH-1:0]        pdm_out,
   input logic                     bank_en,
   input logic [NUM_CH-1:0]        step_tick,
   input logic [NUM_CH-1:0]        pre_wr,
   input logic [NUM_CH*DENS_W-1:0] dens_flat,
   input logic [NUM_CH*PRE_W-1:0]  pre_flat
);
   import sdm_pkg::*;

   AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en |=> $stable(pdm_out)); // R2

   AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr > ADDR_W'(last_addr(NUM_CH)))
      |=> ($stable(bank_en) && $stable(dens_flat) && $stable(pre_flat))); // R9

   AST_NO_STEP_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en |-> (step_tick == '0)); // R2

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [PRE_W:0] gap_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        gap_q <= '0;
         else if (pre_wr[ch] || step_tick[ch]) gap_q <= '0;
         else if (bank_en)                  gap_q <= gap_q + 1'b1;
      end

      AST_OUT_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         !step_tick[ch] |=> $stable(pdm_out[ch])); // R3

      AST_STEP_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         bank_en |-> (gap_q <= {1'b0, pre_flat[ch*PRE_W +: PRE_W]})); // R3

      AST_RESTART_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         pre_wr[ch] |-> !step_tick[ch]); // R6

      AST_DENS_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_addr == ADDR_W'(dens_addr(ch)))
         |=> ($stable(pre_flat) && $stable(bank_en))); // R8
   end

endmodule

bind sdm_bank sdm_bank_chk #(
   .NUM_CH (NUM_CH),
   .DENS_W (DENS_W),
   .PRE_W  (PRE_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .pdm_out   (pdm_out),
   .bank_en   (bank_en),
   .step_tick (step_tick),
   .pre_wr    (pre_wr),
   .dens_flat (dens_flat),
   .pre_flat  (pre_flat)
);

// File: tb/tb_sdm_bank.sv
`timescale 1ns/1ps
module tb_sdm_bank;
   localparam int NCH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [3:0] pdm_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   always #10 clk = ~clk;

   sdm_bank dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .pdm_out   (pdm_out)
   );

   // reference state, built from the requirements
   logic       m_en;
   logic [7:0] m_dens [NCH];
   logic [7:0] m_pre  [NCH];
   logic [7:0] m_cnt  [NCH];
   logic [7:0] m_res  [NCH];
   logic       m_out  [NCH];

   function automatic logic [8:0] step_sum(input logic [7:0] r, input logic [7:0] d);
      return {1'b0, r} + {1'b0, d};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en <= 1'b0;
         for (int c = 0; c < NCH; c++) begin
            m_dens[c] <= 8'd0; m_pre[c] <= 8'd255; m_cnt[c] <= 8'd0;
            m_res[c] <= 8'd0;  m_out[c] <= 1'b0;
         end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            automatic logic wpre = cfg_we && cfg_addr == 4'(2*c+2);
            automatic logic stp  = m_en && !wpre && m_cnt[c] == m_pre[c];
            automatic logic [8:0] s = step_sum(m_res[c], m_dens[c]);
            if (wpre)      m_cnt[c] <= 8'd0;
            else if (m_en) m_cnt[c] <= stp ? 8'd0 : m_cnt[c] + 8'd1;
            if (stp) begin m_res[c] <= s[7:0]; m_out[c] <= s[8]; end
            if (cfg_we && cfg_addr == 4'(2*c+1)) m_dens[c] <= cfg_wdata;
            if (wpre) m_pre[c] <= cfg_wdata;
         end
         if (cfg_we && cfg_addr == 4'd0) m_en <= cfg_wdata[0];
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the reference (R4, R8, R10)
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         for (int c = 0; c < NCH; c++)
            check("R4", int'(pdm_out[c]), int'(m_out[c]));
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int ones;
      int wait_cnt;
      logic [3:0] held;
      void'($urandom(32'd2024));
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", int'(pdm_out), 0);
      cmp_on = 1'b1;

      // R2: gated bank does not modulate, though writes land
      wr(4'd1, 8'd200);
      wr(4'd2, 8'd0);
      idle(20);
      check("R2", int'(pdm_out), 0);

      // R1/R3: channel 1 keeps default prescale 255, density 128
      wr(4'd3, 8'd128);
      wr(4'd0, 8'd1);                    // R10: enable lands at this write's edge
      wait_cnt = 0;
      while (!pdm_out[1] && wait_cnt < 2000) begin
         @(negedge clk); wait_cnt++;
      end
      check("R3", wait_cnt, 512);

      // R5: 256 steps at density 77 with prescale 0
      wr(4'd1, 8'd77);
      ones = 0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk); ones += int'(pdm_out[0]);
      end
      check("R5", ones, 77);

      // R7: density 0 and density 255 on channel 2 at prescale 0
      wr(4'd6, 8'd0);
      wr(4'd5, 8'd0);
      idle(2);
      ones = 0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk); ones += int'(pdm_out[2]);
      end
      check("R7", ones, 0);
      wr(4'd5, 8'd255);
      idle(1);
      ones = 0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk); ones += int'(pdm_out[2]);
      end
      check("R7", ones, 255);

      // R6: prescale write on channel 3 restarts its divider
      wr(4'd7, 8'd128);
      wr(4'd8, 8'd3);
      idle(2);
      wr(4'd8, 8'd3);                    // restart mid-count; reference tracks R6
      idle(12);
      check("R6", int'(pdm_out[3]), int'(m_out[3]));

      // R2: gate off freezes outputs while densities change
      wr(4'd0, 8'd0);
      held = pdm_out;
      wr(4'd1, 8'd9);
      wr(4'd3, 8'd250);
      idle(30);
      check("R2", int'(pdm_out), int'(held));

      // R9: unmapped writes change nothing
      wr(4'd0, 8'd1);
      for (int a = 9; a < 16; a++) wr(4'(a), 8'hFF);
      idle(40);
      check("R9", int'(m_en), 1);

      // R8: random traffic over the whole address range
      for (int i = 0; i < 3000; i++) begin
         automatic int r = int'($urandom_range(0, 7));
         if (r == 0) begin
            automatic logic [3:0] a = 4'($urandom_range(0, 15));
            automatic logic [7:0] d = 8'($urandom_range(0, 255));
            if (a[0] == 1'b0 && a != 4'd0 && a <= 4'd8) d = 8'($urandom_range(0, 7));
            if (a == 4'd0) d = ($urandom_range(0, 9) == 0) ? 8'd0 : 8'd1;
            wr(a, d);
         end else begin
            @(negedge clk);
         end
      end
      check("R8", int'(pdm_out), {int'(m_out[3]), int'(m_out[2]), int'(m_out[1]), int'(m_out[0])} == 0 ? 0 :
            int'({m_out[3], m_out[2], m_out[1], m_out[0]}));

      cmp_on = 1'b0;
      finish_run();
   end

endmodule